// File: doc/BRIEF.md
# Audio Serial Output Formatter

This block sits behind the decoder of a consumer digital audio receiver. The decoder hands over one audio word per subframe on a strobe that also names the channel and carries a parity-error flag. The block keeps the last good word of each channel and sends the words out on a three-wire serial link made of a bit clock, a left/right clock and a data line. It also derives two side clocks, 384Fs and 256Fs, that keep a fixed phase to the serial frame. It runs from the recovered 768Fs master clock.

A format input picks one of two word framings. In the long framing, 20 bits go out LSB first, right-justified in each 32-bit half-frame. In the short framing, the upper 16 bits go out MSB first, left-justified. The format is taken only at a frame start, so a change never splits a word. A word flagged as bad is dropped, and the channel repeats its previous good word. A halt input stops all timing and holds every output low. The first master cycle after the halt is released is the first cycle of a new frame.

Top module: `aud_serial_fmt`

## Requirements
- R1: With `fmt_long` = 1 at the frame start, each half-frame carries the 20-bit word LSB first. Bit slots 0..11 of the half are 0, and slot 12+k carries word bit k (k = 0..19).
- R2: With `fmt_long` = 0 at the frame start, slot k (k = 0..15) of each half carries word bit 19-k, and slots 16..31 are 0.
- R3: One bit slot lasts 12 master cycles. `bclk` is low in the first 6 cycles of a slot and high in the last 6. `sdata` and `lrck` change only in the cycle where `bclk` falls.
- R4: A frame is 64 slots (768 master cycles). `lrck` is 1 for slots 0..31, which carry the left word, and 0 for slots 32..63, which carry the right word.
- R5: A strobe with `smp_err` = 1 changes neither channel's held word. The affected channel repeats its last good word, and the other channel is unaffected.
- R6: `clk384` is 1 on even master cycles of the frame and 0 on odd ones. `clk256` has period 3, is 1 for two cycles and 0 for one, and is 1 in frame cycles 0 and 1.
- R7: `fmt_long` is sampled only when a frame begins. A change in mid-frame leaves the rest of that frame unchanged and takes effect from the next frame.
- R8: While `rst_n` = 0 or `halt` = 1, all five outputs are 0. In the first cycle after `halt` is released, the block is in frame cycle 0 and sends the held left word.
- R9: The left word is captured in the last cycle of a frame, and the right word in the last cycle of the left half. A strobe accepted in that same cycle is not captured; it reaches the serial line one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 768Fs recovered master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Stop: clears timing and holds outputs low |
| fmt_long | input | 1 | 1 = 20-bit LSB first, 0 = 16-bit MSB first |
| smp_stb | input | 1 | One-cycle strobe: a decoded word is present |
| smp_right | input | 1 | Channel of the strobed word: 0 left, 1 right |
| smp_err | input | 1 | Parity error flag of the strobed word |
| smp_data | input | 20 | Decoded audio word |
| bclk | output | 1 | Serial bit clock, 64Fs |
| lrck | output | 1 | Left/right clock, 1 = left |
| sdata | output | 1 | Serial audio data |
| clk384 | output | 1 | 384Fs clock |
| clk256 | output | 1 | 256Fs clock, 2:1 duty |

## Verification
The two functions that can meet in one cycle are the capture of a held word into the output stage and the arrival of a new decoded word for the same channel. The bench puts a strobe exactly in the capture cycle of each channel, and one cycle earlier for comparison. It then reads back the serialised words of the following frames and judges each one against the values held before and after the strobe. A format change in mid-frame is provoked in the same way and judged on both halves of the current frame and the next one.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;
  localparam int WORD_W     = 20;
  localparam int SHORT_W    = 16;
  localparam int HALF_SLOTS = 32;

  // Bit carried by half-frame slot s for a given word and framing.
  function automatic logic slot_bit(input logic [WORD_W-1:0] w,
                                    input logic long_fmt,
                                    input int s);
    logic [WORD_W-1:0] t;
    t = '0;
    if (long_fmt) begin
      if (s >= HALF_SLOTS - WORD_W) t = w >> (s - (HALF_SLOTS - WORD_W));
    end else if (s < SHORT_W) begin
      t = w >> (WORD_W - 1 - s);
    end
    return t[0];
  endfunction
endpackage

// File: rtl/aud_timebase.sv
module aud_timebase #(
  parameter int MCLK_PER_BIT   = 12,
  parameter int BITS_PER_FRAME = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic run,
  output logic [$clog2(BITS_PER_FRAME)-2:0] half_slot,
  output logic bclk,
  output logic lrck,
  output logic clk384,
  output logic clk256,
  output logic load_left,
  output logic load_right
);
  localparam int SUB_W   = $clog2(MCLK_PER_BIT);
  localparam int SLOT_W  = $clog2(BITS_PER_FRAME);
  localparam int HALF    = BITS_PER_FRAME / 2;
  localparam int BCLK_HI = MCLK_PER_BIT / 2;

  logic [SUB_W-1:0]  sub;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] hs;
  logic [1:0]        m3;
  logic bit_end, frame_end, half_end;

  assign bit_end   = run && (sub == SUB_W'(MCLK_PER_BIT - 1));
  assign frame_end = bit_end && (slot == SLOT_W'(BITS_PER_FRAME - 1));
  assign half_end  = bit_end && (slot == SLOT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; sub <= '0; slot <= '0; m3 <= '0;
    end else if (halt) begin
      run <= 1'b0; sub <= '0; slot <= '0; m3 <= '0;
    end else if (!run) begin
      run <= 1'b1;
    end else begin
      if (bit_end) begin
        sub  <= '0;
        slot <= frame_end ? '0 : slot + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
      m3 <= (m3 == 2'd2) ? 2'd0 : m3 + 2'd1;
    end
  end

  assign hs         = (slot >= SLOT_W'(HALF)) ? slot - SLOT_W'(HALF) : slot;
  assign half_slot  = hs[SLOT_W-2:0];
  assign bclk       = run && (sub >= SUB_W'(BCLK_HI));
  assign lrck       = run && (slot < SLOT_W'(HALF));
  assign clk384     = run && !sub[0];
  assign clk256     = run && (m3 != 2'd2);
  assign load_left  = halt || !run || frame_end;
  assign load_right = half_end;

  // R6: 384Fs toggles every master cycle while running
  a_r6_clk384_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (clk384 != $past(clk384)));
  // R6: 256Fs low phase lasts exactly one cycle
  a_r6_clk256_low_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clk256) |=> (clk256 || !run));
  // R6: 256Fs high phase lasts two cycles
  a_r6_clk256_high_two: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $rose(clk256)) |=> (clk256 || !run));
endmodule

// File: rtl/aud_sample_hold.sv
module aud_sample_hold
  import aud_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              right,
  input  logic              err,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] hold_l,
  output logic [WORD_W-1:0] hold_r
);
  logic acc_l, acc_r;
  assign acc_l = stb && !err && !right;
  assign acc_r = stb && !err &&  right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else begin
      if (acc_l) hold_l <= data;
      if (acc_r) hold_r <= data;
    end
  end

  // R5: an errored word leaves both held words as they were
  a_r5_err_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && err) |=> (hold_l == $past(hold_l) && hold_r == $past(hold_r)));
  // R5: a good word only touches its own channel
  a_r5_other_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !err && right) |=> (hold_l == $past(hold_l)));
endmodule

// File: rtl/aud_word_shifter.sv
module aud_word_shifter
  import aud_fmt_pkg::*;
#(
  parameter int HS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_left,
  input  logic              load_right,
  input  logic              fmt_long,
  input  logic [WORD_W-1:0] hold_l,
  input  logic [WORD_W-1:0] hold_r,
  input  logic [HS_W-1:0]   half_slot,
  output logic              sdata
);
  logic [WORD_W-1:0] cur_word;
  logic              cur_fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_word <= '0;
      cur_fmt  <= 1'b0;
    end else if (load_left) begin
      cur_word <= hold_l;
      cur_fmt  <= fmt_long;
    end else if (load_right) begin
      cur_word <= hold_r;
    end
  end

  assign sdata = run && slot_bit(cur_word, cur_fmt, int'(half_slot));

  // R7: the framing changes only at a frame start
  a_r7_fmt_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_fmt != $past(cur_fmt)) |-> $past(load_left));
  // R9: the right word comes from the value held before the capture edge
  a_r9_right_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_right) |-> (cur_word == $past(hold_r)));
endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt
  import aud_fmt_pkg::*;
#(
  parameter int MCLK_PER_BIT   = 12,
  parameter int BITS_PER_FRAME = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              fmt_long,
  input  logic              smp_stb,
  input  logic              smp_right,
  input  logic              smp_err,
  input  logic [WORD_W-1:0] smp_data,
  output logic              bclk,
  output logic              lrck,
  output logic              sdata,
  output logic              clk384,
  output logic              clk256
);
  localparam int HS_W = $clog2(BITS_PER_FRAME) - 1;

  logic              run, load_left, load_right;
  logic [HS_W-1:0]   half_slot;
  logic [WORD_W-1:0] hold_l, hold_r;

  aud_timebase #(.MCLK_PER_BIT(MCLK_PER_BIT), .BITS_PER_FRAME(BITS_PER_FRAME)) u_tb (
    .clk(clk), .rst_n(rst_n), .halt(halt), .run(run), .half_slot(half_slot),
    .bclk(bclk), .lrck(lrck), .clk384(clk384), .clk256(clk256),
    .load_left(load_left), .load_right(load_right));

  aud_sample_hold u_hold (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .right(smp_right), .err(smp_err),
    .data(smp_data), .hold_l(hold_l), .hold_r(hold_r));

  aud_word_shifter #(.HS_W(HS_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .load_left(load_left),
    .load_right(load_right), .fmt_long(fmt_long), .hold_l(hold_l),
    .hold_r(hold_r), .half_slot(half_slot), .sdata(sdata));

  // R3: data moves only with a falling bit clock
  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && sdata != $past(sdata)) |-> $fell(bclk));
  // R3: the left/right clock moves only with a falling bit clock
  a_r3_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && lrck != $past(lrck)) |-> $fell(bclk));
  // R8: halt silences every output
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !(bclk || lrck || sdata || clk384 || clk256));
endmodule

// File: tb/tb_aud_serial_fmt.sv
module tb_aud_serial_fmt;
  localparam int FRAME = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0, halt = 1'b1, fmt_long = 1'b1;
  logic smp_stb = 1'b0, smp_right = 1'b0, smp_err = 1'b0;
  logic [19:0] smp_data = '0;
  logic bclk, lrck, sdata, clk384, clk256;
  int checks = 0, failures = 0;
  logic [FRAME-1:0] rb, rl, rs, r3, r2;

  always #2 clk = ~clk;

  aud_serial_fmt dut (.clk(clk), .rst_n(rst_n), .halt(halt), .fmt_long(fmt_long),
    .smp_stb(smp_stb), .smp_right(smp_right), .smp_err(smp_err), .smp_data(smp_data),
    .bclk(bclk), .lrck(lrck), .sdata(sdata), .clk384(clk384), .clk256(clk256));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pattern(input bit long_f, input logic [19:0] w);
    logic [31:0] p = '0;
    if (long_f) for (int k = 0; k < 20; k++) p[12 + k] = w[k];
    else        for (int k = 0; k < 16; k++) p[k] = w[19 - k];
    return p;
  endfunction

  // Call right after the edge that starts frame cycle 0.
  task automatic record_frame(input int inj_c, input bit inj_r, input logic [19:0] inj_d,
                              input int fchg_c, input bit fnew);
    for (int c = 0; c < FRAME; c++) begin
      #1;
      rb[c] = bclk; rl[c] = lrck; rs[c] = sdata; r3[c] = clk384; r2[c] = clk256;
      smp_stb = (c == inj_c); smp_right = inj_r; smp_err = 1'b0; smp_data = inj_d;
      if (c == fchg_c) fmt_long = fnew;
      @(posedge clk);
    end
  endtask

  task automatic check_half(input int ch, input bit long_f, input logic [19:0] w, input string req);
    logic [31:0] act;
    for (int s = 0; s < 32; s++) act[s] = rs[(ch * 32 + s) * 12 + 9];
    chk(act == exp_pattern(long_f, w), req, 64'(act), 64'(exp_pattern(long_f, w)));
  endtask

  task automatic check_timing();
    int bad3 = 0, bad4 = 0, bad6 = 0;
    for (int c = 0; c < FRAME; c++) begin
      if (rb[c] != ((c % 12) >= 6)) bad3++;
      if (c > 0 && (rs[c] != rs[c-1] || rl[c] != rl[c-1]) && !(rb[c-1] && !rb[c])) bad3++;
      if (rl[c] != (c < 384)) bad4++;
      if (r3[c] != ((c % 2) == 0) || r2[c] != ((c % 3) != 2)) bad6++;
    end
    chk(bad3 == 0, "R3 bit clock and edge timing", 64'(bad3), 0);
    chk(bad4 == 0, "R4 lrck halves", 64'(bad4), 0);
    chk(bad6 == 0, "R6 side clocks", 64'(bad6), 0);
  endtask

  task automatic send(input bit right, input logic [19:0] d, input bit err);
    @(negedge clk); smp_stb = 1'b1; smp_right = right; smp_data = d; smp_err = err;
    @(negedge clk); smp_stb = 1'b0; smp_err = 1'b0;
  endtask

  task automatic stop_it();
    @(negedge clk); halt = 1'b1; smp_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_it();
    @(negedge clk); halt = 1'b0; smp_stb = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk({bclk, lrck, sdata, clk384, clk256} == 5'b0, "R8 outputs low in reset",
        64'({bclk, lrck, sdata, clk384, clk256}), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_long();
    stop_it(); fmt_long = 1'b1;
    send(1'b0, 20'h12345, 1'b0); send(1'b1, 20'hABCDE, 1'b0);
    release_it();
    record_frame(-1, 1'b0, '0, -1, 1'b0);
    chk(rs[0] == 1'b0 && rl[0] && r3[0] && r2[0] && !rb[0], "R8 first cycle after release",
        64'({rb[0], rl[0], r3[0], r2[0]}), 64'b0111);
    check_timing();
    check_half(0, 1'b1, 20'h12345, "R1 left long");
    check_half(1, 1'b1, 20'hABCDE, "R1 right long");
  endtask

  task automatic t_short();
    stop_it(); fmt_long = 1'b0;
    send(1'b0, 20'hF0F0A, 1'b0); send(1'b1, 20'h5A5A5, 1'b0);
    release_it();
    record_frame(-1, 1'b0, '0, -1, 1'b0);
    check_timing();
    check_half(0, 1'b0, 20'hF0F0A, "R2 left short");
    check_half(1, 1'b0, 20'h5A5A5, "R2 right short");
  endtask

  task automatic t_error();
    stop_it(); fmt_long = 1'b1;
    send(1'b0, 20'h0A1A1, 1'b0); send(1'b0, 20'h0B2B2, 1'b1);
    send(1'b1, 20'h0C3C3, 1'b0); send(1'b1, 20'h0D4D4, 1'b1);
    release_it();
    record_frame(-1, 1'b0, '0, -1, 1'b0);
    check_half(0, 1'b1, 20'h0A1A1, "R5 left keeps good word");
    check_half(1, 1'b1, 20'h0C3C3, "R5 right keeps good word");
  endtask

  task automatic t_fmt_and_collide();
    stop_it(); fmt_long = 1'b1;
    send(1'b0, 20'h11111, 1'b0); send(1'b1, 20'h22222, 1'b0);
    release_it();
    record_frame(-1, 1'b0, '0, 100, 1'b0);
    check_half(1, 1'b1, 20'h22222, "R7 mid-frame change not applied");
    record_frame(383, 1'b1, 20'h44444, -1, 1'b0);
    check_half(0, 1'b0, 20'h11111, "R7 change applied next frame");
    check_half(1, 1'b0, 20'h22222, "R9 right strobe in capture cycle not taken");
    record_frame(767, 1'b0, 20'h33333, -1, 1'b0);
    check_half(1, 1'b0, 20'h44444, "R9 right strobe shows next frame");
    record_frame(766, 1'b0, 20'h55555, -1, 1'b0);
    check_half(0, 1'b0, 20'h11111, "R9 left strobe in capture cycle not taken");
    record_frame(-1, 1'b0, '0, -1, 1'b0);
    check_half(0, 1'b0, 20'h55555, "R9 left strobe before capture taken");
  endtask

  task automatic t_halt();
    int bad = 0;
    repeat (200) @(negedge clk);
    halt = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if ({bclk, lrck, sdata, clk384, clk256} != 5'b0) bad++;
    end
    chk(bad == 0, "R8 outputs low while halted", 64'(bad), 0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_long();
    t_short();
    t_error();
    t_fmt_and_collide();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule